// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides whether a finished CAN frame is kept, and which message slot gets it. It has fifteen slots. Each slot holds its own settings: an enable bit, a format bit that selects 11-bit or 29-bit identifiers, an identifier value, and a bit that turns on masking. Slots that turn on masking use a global mask. There is one global mask for standard frames and a separate one for extended frames. A global mask bit of 1 means that identifier bit must match. A mask bit of 0 means that bit is ignored.

When the receiver pulses the frame strobe, the block takes a snapshot of the frame and of the current slot settings. A state machine then walks the slots in ascending order, from slot 1 upward. Each step costs one clock cycle. The first enabled slot that matches ends the walk, and the block raises a one-cycle load pulse together with that slot's number. If no slot matches, the block raises the done pulse with slot 0 and no load. A frame that arrives marked with an error is not searched at all; it is dropped.

The state machine has three states: `ST_IDLE` (waiting for a frame), `ST_SCAN` (testing one slot per cycle) and `ST_DROP` (throwing away an errored frame). Its transitions are:
- IDLE→SCAN on a strobe with a clean frame.
- IDLE→DROP on a strobe with an errored frame.
- SCAN→SCAN when the current slot misses and it is not the last slot.
- SCAN→IDLE on a hit, or when the last slot misses.
- DROP→IDLE unconditionally.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, `res_done`, `res_load`, `res_slot` and `filt_busy` are all 0. Every slot is disabled, so any frame is rejected.
- R2: A slot whose enable bit is 0 never accepts a frame.
- R3: Slots are tested in ascending order. The lowest-numbered matching slot wins. If slot k accepts a frame whose strobe was sampled at clock edge E, then `res_load` and `res_done` are high, and `res_slot` equals k, in the cycle after edge E+k.
- R4: A standard-format slot compares only identifier bits [10:0]. For a standard frame, bits [28:11] of `frm_id` are ignored. With masking off, all 11 bits must be equal.
- R5: An extended-format slot compares all 29 identifier bits. With masking off, every bit must be equal.
- R6: A slot never accepts a frame of the other format. `frm_ext` is 1 for a 29-bit frame and 0 for an 11-bit frame. `cfg_ext` uses the same encoding.
- R7: When a slot's mask bit is set, an identifier bit takes part in the comparison only where the global mask for that slot's format holds a 1. The standard mask covers bits [10:0]. The extended mask covers bits [28:0].
- R8: A frame whose strobe arrives with `frm_err` = 1 gives `res_done` = 1, `res_load` = 0 and `res_slot` = 0 in the cycle after edge E+1.
- R9: When no slot accepts a clean frame, `res_done` is high in the cycle after edge E+15, with `res_load` = 0 and `res_slot` = 0.
- R10: While `filt_busy` is 1, a frame strobe is ignored. It produces no result of its own.
- R11: A slot or global mask write made during a search does not affect that search. It takes effect from the next accepted strobe onward.
- R12: `res_load` lasts exactly one cycle. It always comes with `res_done`. `res_slot` is 0 whenever `res_load` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the settings of one slot |
| cfg_slot | input | 4 | Slot number to write (1–15); any other value is ignored |
| cfg_enable | input | 1 | Slot enable |
| cfg_ext | input | 1 | Slot format: 1 means 29-bit, 0 means 11-bit |
| cfg_mask | input | 1 | Slot uses the global mask for its format |
| cfg_id | input | 29 | Slot identifier; a standard slot uses bits [10:0] |
| gmask_we | input | 1 | Write strobe for both global masks |
| gmask_std | input | 11 | Global mask for standard frames (1 = must match) |
| gmask_ext | input | 29 | Global mask for extended frames (1 = must match) |
| frm_valid | input | 1 | One-cycle strobe: a received frame is complete |
| frm_id | input | 29 | Received identifier; a standard frame uses bits [10:0] |
| frm_ext | input | 1 | Received frame is in 29-bit format |
| frm_err | input | 1 | Received frame contained an error |
| filt_busy | output | 1 | A search or a drop is in progress |
| res_done | output | 1 | One-cycle pulse: a search has finished |
| res_load | output | 1 | One-cycle pulse: the frame is to be stored in `res_slot` |
| res_slot | output | 4 | Number of the accepting slot; 0 when there is no load |

## Verification
The test frames are chosen so that each one separates two possible designs.

- **Exact hits and near misses.** Frames that match exactly are paired with frames that differ in only the lowest identifier bit. This separates a full comparison from a partial one.
- **Standard frames with high bits set.** A standard frame is sent with bits [28:11] of `frm_id` set. This shows whether the upper bits leak into an 11-bit comparison.
- **Cross-format frames.** An extended slot and a standard slot are given identifiers that share their low bits, and frames of the wrong format are sent at them. This separates a check on the format bit from a plain comparison of identifiers.
- **Overlapping slots.** Two slots are set to the same identifier, and a frame is also sent that only slot 15 accepts. These show the priority order and the per-slot latency, and they separate a hit from a miss at the boundary cycle.
- **Masked comparisons.** Frames that differ only in masked-off bits are paired with frames that differ in a masked-in bit. This checks the mask polarity and that the two global masks are kept separate.
- **Timing of strobes and writes.** Strobes and setting writes that land during a search confirm that the search ignores both.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

    localparam int STD_W = 11;
    localparam int EXT_W = 29;

    typedef struct packed {
        logic             en;
        logic             ext;
        logic             msk;
        logic [EXT_W-1:0] id;
    } slot_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DROP = 2'd2
    } scan_state_t;

endpackage

// File: rtl/can_filt_cfg_bank.sv
module can_filt_cfg_bank
    import can_filt_pkg::*;
#(
    parameter int NUM_SLOTS = 15,
    parameter int SLOT_W    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SLOT_W-1:0]       wr_slot,
    input  slot_cfg_t               wr_cfg,
    input  logic                    gm_we,
    input  logic [STD_W-1:0]        gm_std_in,
    input  logic [EXT_W-1:0]        gm_ext_in,
    input  logic                    snap,
    output slot_cfg_t [NUM_SLOTS-1:0] act_cfg,
    output logic [STD_W-1:0]        act_gm_std,
    output logic [EXT_W-1:0]        act_gm_ext
);

    // Staging copy of the global masks; written at any time.
    logic [STD_W-1:0] stg_gm_std;
    logic [EXT_W-1:0] stg_gm_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_gm_std <= '1;
            stg_gm_ext <= '1;
        end else if (gm_we) begin
            stg_gm_std <= gm_std_in;
            stg_gm_ext <= gm_ext_in;
        end
    end

    // The active masks are copied from staging when a frame is accepted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_gm_std <= '1;
            act_gm_ext <= '1;
        end else if (snap) begin
            act_gm_std <= stg_gm_std;
            act_gm_ext <= stg_gm_ext;
        end
    end

    // One staging register and one active register for each slot.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic [SLOT_W-1:0] SLOT_NUM = SLOT_W'(g + 1);
        slot_cfg_t stg_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q <= '0;
            end else if (wr_en && (wr_slot == SLOT_NUM)) begin
                stg_q <= wr_cfg;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_cfg[g] <= '0;
            end else if (snap) begin
                act_cfg[g] <= stg_q;
            end
        end
    end

endmodule

// File: rtl/can_filt_slot_match.sv
module can_filt_slot_match
    import can_filt_pkg::*;
(
    input  slot_cfg_t        cfg,
    input  logic [STD_W-1:0] gm_std,
    input  logic [EXT_W-1:0] gm_ext,
    input  logic [EXT_W-1:0] f_id,
    input  logic             f_ext,
    output logic             hit
);

    logic [EXT_W-1:0] diff;
    logic [EXT_W-1:0] care_ext;
    logic [STD_W-1:0] care_std;
    logic             ext_eq;
    logic             std_eq;

    always_comb begin
        diff     = cfg.id ^ f_id;
        care_ext = cfg.msk ? gm_ext : '1;
        care_std = cfg.msk ? gm_std : '1;
        ext_eq   = ((diff & care_ext) == '0);
        std_eq   = ((diff[STD_W-1:0] & care_std) == '0);
        if (!cfg.en) begin
            hit = 1'b0;
        end else if (cfg.ext) begin
            hit = f_ext && ext_eq;
        end else begin
            hit = !f_ext && std_eq;
        end
    end

endmodule

// File: rtl/can_filt_scan_fsm.sv
module can_filt_scan_fsm
    import can_filt_pkg::*;
#(
    parameter int NUM_SLOTS = 15,
    parameter int SLOT_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_valid,
    input  logic                 frm_err,
    input  logic [NUM_SLOTS-1:0] hit_vec,
    output logic                 start,
    output logic                 busy,
    output logic                 load,
    output logic [SLOT_W-1:0]    load_slot,
    output logic                 done
);

    localparam logic [SLOT_W-1:0] FIRST_SLOT = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(NUM_SLOTS);

    scan_state_t       state, nxt_state;
    logic [SLOT_W-1:0] idx, nxt_idx;
    logic              cur_hit;
    logic              fire_done;
    logic              fire_load;
    logic [SLOT_W-1:0] fire_slot;

    // Select the hit bit of the slot under test.
    always_comb begin
        cur_hit = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (idx == SLOT_W'(i + 1)) begin
                cur_hit = hit_vec[i];
            end
        end
    end

    // Next state and the result of this step.
    always_comb begin
        nxt_state = state;
        nxt_idx   = idx;
        start     = 1'b0;
        fire_done = 1'b0;
        fire_load = 1'b0;
        fire_slot = '0;
        unique case (state)
            ST_IDLE: begin
                if (frm_valid) begin
                    start     = 1'b1;
                    nxt_idx   = FIRST_SLOT;
                    nxt_state = frm_err ? ST_DROP : ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (cur_hit) begin
                    fire_done = 1'b1;
                    fire_load = 1'b1;
                    fire_slot = idx;
                    nxt_state = ST_IDLE;
                end else if (idx == LAST_SLOT) begin
                    fire_done = 1'b1;
                    nxt_state = ST_IDLE;
                end else begin
                    nxt_idx = idx + FIRST_SLOT;
                end
            end
            ST_DROP: begin
                fire_done = 1'b1;
                nxt_state = ST_IDLE;
            end
            default: begin
                nxt_state = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= nxt_state;
            idx   <= nxt_idx;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            load      <= 1'b0;
            load_slot <= '0;
        end else begin
            done      <= fire_done;
            load      <= fire_load;
            load_slot <= fire_slot;
        end
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_SLOTS = 15,
    parameter int SLOT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic              cfg_enable,
    input  logic              cfg_ext,
    input  logic              cfg_mask,
    input  logic [EXT_W-1:0]  cfg_id,
    input  logic              gmask_we,
    input  logic [STD_W-1:0]  gmask_std,
    input  logic [EXT_W-1:0]  gmask_ext,
    input  logic              frm_valid,
    input  logic [EXT_W-1:0]  frm_id,
    input  logic              frm_ext,
    input  logic              frm_err,
    output logic              filt_busy,
    output logic              res_done,
    output logic              res_load,
    output logic [SLOT_W-1:0] res_slot
);

    slot_cfg_t                  wr_cfg;
    slot_cfg_t [NUM_SLOTS-1:0]  act_cfg;
    logic [STD_W-1:0]           act_gm_std;
    logic [EXT_W-1:0]           act_gm_ext;
    logic [NUM_SLOTS-1:0]       hit_vec;
    logic [NUM_SLOTS-1:0]       act_en;
    logic                       start;
    logic [EXT_W-1:0]           f_id;
    logic                       f_ext;

    assign wr_cfg.en  = cfg_enable;
    assign wr_cfg.ext = cfg_ext;
    assign wr_cfg.msk = cfg_mask;
    assign wr_cfg.id  = cfg_id;

    // Snapshot of the frame taken when it is accepted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_id  <= '0;
            f_ext <= 1'b0;
        end else if (start) begin
            f_id  <= frm_id;
            f_ext <= frm_ext;
        end
    end

    can_filt_cfg_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_slot    (cfg_slot),
        .wr_cfg     (wr_cfg),
        .gm_we      (gmask_we),
        .gm_std_in  (gmask_std),
        .gm_ext_in  (gmask_ext),
        .snap       (start),
        .act_cfg    (act_cfg),
        .act_gm_std (act_gm_std),
        .act_gm_ext (act_gm_ext)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        can_filt_slot_match u_match (
            .cfg    (act_cfg[g]),
            .gm_std (act_gm_std),
            .gm_ext (act_gm_ext),
            .f_id   (f_id),
            .f_ext  (f_ext),
            .hit    (hit_vec[g])
        );
        assign act_en[g] = act_cfg[g].en;
    end

    can_filt_scan_fsm #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .frm_err   (frm_err),
        .hit_vec   (hit_vec),
        .start     (start),
        .busy      (filt_busy),
        .load      (res_load),
        .load_slot (res_slot),
        .done      (res_done)
    );

endmodule

// File: rtl/can_filt_chk.sv
module can_filt_chk #(
    parameter int NUM_SLOTS = 15,
    parameter int SLOT_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frm_valid,
    input logic                 frm_err,
    input logic                 busy,
    input logic                 load,
    input logic [SLOT_W-1:0]    load_slot,
    input logic                 done,
    input logic [NUM_SLOTS-1:0] act_en
);

    logic            accept;
    logic            slot_en_ok;
    logic [SLOT_W:0] busy_cnt;

    assign accept = frm_valid && !busy;

    always_comb begin
        slot_en_ok = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (load_slot == SLOT_W'(i + 1)) begin
                slot_en_ok = act_en[i];
            end
        end
    end

    // Count the cycles spent busy; the search has a bounded length.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (!busy) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assert_load_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    assert_load_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> done);

    assert_slot_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !load |-> (load_slot == '0));

    assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> ((load_slot != '0) && (load_slot <= SLOT_W'(NUM_SLOTS))));

    assert_load_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> slot_en_ok);

    assert_err_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && frm_err) |=> ##1 (done && !load));

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_latency_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= (SLOT_W + 1)'(NUM_SLOTS));

endmodule

bind can_accept_filter can_filt_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_valid (frm_valid),
    .frm_err   (frm_err),
    .busy      (filt_busy),
    .load      (res_load),
    .load_slot (res_slot),
    .done      (res_done),
    .act_en    (act_en)
);

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb;

    logic        clk;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_slot;
    logic        cfg_enable;
    logic        cfg_ext;
    logic        cfg_mask;
    logic [28:0] cfg_id;
    logic        gmask_we;
    logic [10:0] gmask_std;
    logic [28:0] gmask_ext;
    logic        frm_valid;
    logic [28:0] frm_id;
    logic        frm_ext;
    logic        frm_err;
    logic        filt_busy;
    logic        res_done;
    logic        res_load;
    logic [3:0]  res_slot;

    int n_checks = 0;
    int n_fails  = 0;

    can_accept_filter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_slot   (cfg_slot),
        .cfg_enable (cfg_enable),
        .cfg_ext    (cfg_ext),
        .cfg_mask   (cfg_mask),
        .cfg_id     (cfg_id),
        .gmask_we   (gmask_we),
        .gmask_std  (gmask_std),
        .gmask_ext  (gmask_ext),
        .frm_valid  (frm_valid),
        .frm_id     (frm_id),
        .frm_ext    (frm_ext),
        .frm_err    (frm_err),
        .filt_busy  (filt_busy),
        .res_done   (res_done),
        .res_load   (res_load),
        .res_slot   (res_slot)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    task automatic write_slot(input int slot, input bit en, input bit ext,
                              input bit msk, input logic [28:0] id);
        @(negedge clk);
        cfg_we     = 1'b1;
        cfg_slot   = 4'(slot);
        cfg_enable = en;
        cfg_ext    = ext;
        cfg_mask   = msk;
        cfg_id     = id;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_masks(input logic [10:0] ms, input logic [28:0] me);
        @(negedge clk);
        gmask_we  = 1'b1;
        gmask_std = ms;
        gmask_ext = me;
        @(negedge clk);
        gmask_we = 1'b0;
    endtask

    // Strobe a frame. On return the strobe edge E has just passed.
    task automatic send(input logic [28:0] id, input bit ext, input bit err);
        @(negedge clk);
        frm_valid = 1'b1;
        frm_id    = id;
        frm_ext   = ext;
        frm_err   = err;
        @(negedge clk);
        frm_valid = 1'b0;
        frm_err   = 1'b0;
    endtask

    // Expect the result after edge E+lat; no done may show earlier.
    task automatic expect_res(input int lat, input bit exp_load, input int exp_slot,
                              input string tag);
        bit early = 1'b0;
        for (int k = 1; k < lat; k++) begin
            @(negedge clk);
            if (res_done) early = 1'b1;
        end
        check(!early, {tag, " no early done"}, int'(early), 0);
        @(negedge clk);
        check(res_done == 1'b1, {tag, " done"}, int'(res_done), 1);
        check(res_load == exp_load, {tag, " load"}, int'(res_load), int'(exp_load));
        check(res_slot == 4'(exp_slot), {tag, " slot"}, int'(res_slot), exp_slot);
        @(negedge clk);
        check(res_load == 1'b0, {tag, " R12 load single cycle"}, int'(res_load), 0);
    endtask

    task automatic t_reset();
        check(res_done == 1'b0 && res_load == 1'b0, "R1 reset pulses", int'({res_done, res_load}), 0);
        check(res_slot == 4'd0, "R1 reset slot", int'(res_slot), 0);
        check(filt_busy == 1'b0, "R1 reset busy", int'(filt_busy), 0);
        send(29'h000, 1'b0, 1'b0);
        expect_res(15, 1'b0, 0, "R1 all slots disabled");
    endtask

    task automatic t_standard();
        write_slot(3, 1'b1, 1'b0, 1'b0, 29'h123);
        send(29'h123, 1'b0, 1'b0);
        expect_res(3, 1'b1, 3, "R4 std exact");
        send(29'h122, 1'b0, 1'b0);
        expect_res(15, 1'b0, 0, "R9 std near miss");
        send(29'h1FFF_F923, 1'b0, 1'b0);
        expect_res(3, 1'b1, 3, "R4 std upper bits ignored");
    endtask

    task automatic t_extended();
        write_slot(5, 1'b1, 1'b1, 1'b0, 29'h1ABCDEF);
        send(29'h1ABCDEF, 1'b1, 1'b0);
        expect_res(5, 1'b1, 5, "R5 ext exact");
        send(29'h1ABCDEE, 1'b1, 1'b0);
        expect_res(15, 1'b0, 0, "R5 ext near miss");
        send(29'h0000123, 1'b1, 1'b0);
        expect_res(15, 1'b0, 0, "R6 ext frame vs std slot");
        send(29'h5EF, 1'b0, 1'b0);
        expect_res(15, 1'b0, 0, "R6 std frame vs ext slot");
    endtask

    task automatic t_priority();
        write_slot(7, 1'b1, 1'b0, 1'b0, 29'h055);
        write_slot(2, 1'b1, 1'b0, 1'b0, 29'h055);
        send(29'h055, 1'b0, 1'b0);
        expect_res(2, 1'b1, 2, "R3 lowest slot wins");
        write_slot(2, 1'b0, 1'b0, 1'b0, 29'h055);
        send(29'h055, 1'b0, 1'b0);
        expect_res(7, 1'b1, 7, "R2 disabled slot skipped");
        write_slot(15, 1'b1, 1'b0, 1'b0, 29'h7FF);
        send(29'h7FF, 1'b0, 1'b0);
        expect_res(15, 1'b1, 15, "R3 last slot hit");
    endtask

    task automatic t_mask();
        write_masks(11'h7F0, 29'h1FFFFF00);
        write_slot(9, 1'b1, 1'b0, 1'b1, 29'h340);
        send(29'h34A, 1'b0, 1'b0);
        expect_res(9, 1'b1, 9, "R7 std masked hit");
        send(29'h35A, 1'b0, 1'b0);
        expect_res(15, 1'b0, 0, "R7 std masked-in bit differs");
        send(29'h12F, 1'b0, 1'b0);
        expect_res(15, 1'b0, 0, "R7 unmasked slot stays exact");
        write_slot(11, 1'b1, 1'b1, 1'b1, 29'h0ABCD00);
        send(29'h0ABCD7F, 1'b1, 1'b0);
        expect_res(11, 1'b1, 11, "R7 ext masked hit");
        send(29'h0ABCE7F, 1'b1, 1'b0);
        expect_res(15, 1'b0, 0, "R7 ext masked-in bit differs");
    endtask

    task automatic t_error();
        send(29'h123, 1'b0, 1'b1);
        expect_res(1, 1'b0, 0, "R8 error frame dropped");
    endtask

    task automatic t_busy_ignore();
        bit extra = 1'b0;
        bit early = 1'b0;
        send(29'h600, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        frm_valid = 1'b1;
        frm_id    = 29'h123;
        frm_ext   = 1'b0;
        @(negedge clk);
        frm_valid = 1'b0;
        for (int k = 4; k < 15; k++) begin
            @(negedge clk);
            if (res_done) early = 1'b1;
        end
        check(!early, "R10 no result from ignored strobe", int'(early), 0);
        @(negedge clk);
        check(res_done && !res_load, "R10 first frame rejected", int'({res_done, res_load}), 2);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (res_done) extra = 1'b1;
        end
        check(!extra, "R10 no late result", int'(extra), 0);
    endtask

    task automatic t_cfg_during_search();
        bit early = 1'b0;
        send(29'h0AA, 1'b0, 1'b0);
        cfg_we     = 1'b1;
        cfg_slot   = 4'd1;
        cfg_enable = 1'b1;
        cfg_ext    = 1'b0;
        cfg_mask   = 1'b0;
        cfg_id     = 29'h0AA;
        @(negedge clk);
        cfg_we = 1'b0;
        for (int k = 2; k < 15; k++) begin
            @(negedge clk);
            if (res_done) early = 1'b1;
        end
        check(!early, "R11 no early done", int'(early), 0);
        @(negedge clk);
        check(res_done && !res_load, "R11 write mid-search ignored", int'({res_done, res_load}), 2);
        send(29'h0AA, 1'b0, 1'b0);
        expect_res(1, 1'b1, 1, "R11 write applies next frame");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_we = 1'b0; cfg_slot = '0; cfg_enable = 1'b0; cfg_ext = 1'b0;
        cfg_mask = 1'b0; cfg_id = '0;
        gmask_we = 1'b0; gmask_std = '0; gmask_ext = '0;
        frm_valid = 1'b0; frm_id = '0; frm_ext = 1'b0; frm_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_standard();
        t_extended();
        t_priority();
        t_mask();
        t_error();
        t_busy_ignore();
        t_cfg_during_search();
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule